// File: doc/BRIEF.md
# Pixel Clear and Sprite Blit Sequencer

This block carries out the two framebuffer operations of a small interpreter-style CPU that take many cycles: wiping the whole screen and XOR-drawing an 8-pixel-wide sprite. The framebuffer is 64 by 32 pixels and holds one bit per pixel. Each address selects exactly one pixel through a 6-bit column and a 5-bit line coordinate. The block touches that memory one pixel per cycle. It has no wide or burst access.

The CPU pulses `start_i` and supplies an operation select, an origin, a row count and a sprite base address. The sequencer then drives framebuffer addresses and write strobes, and fetches sprite bytes through a simple synchronous read port. At the end it raises `done_o` for one cycle, and the CPU goes back to fetching instructions. For a draw, `collide_o` tells whether any lit pixel was turned off.

Both memories have synchronous reads. Data for an address driven in one cycle is presented on the input in the next cycle.

Top module: `pixel_blit_seq`

## Requirements
- R1: Out of reset, `busy_o`, `done_o`, `fb_we_o`, `spr_rd_o` and `collide_o` are all 0.
- R2: A clear (`draw_i`=0) makes exactly 2048 write cycles, each with `fb_wdata_o`=0. `done_o` is high in the 2049th cycle after the edge that accepted the start. Afterwards every pixel is 0.
- R3: The clear visits pixels in order from (x=0,y=0) to (63,31), with y advancing fastest. That is, the address {x,y} counts up by one on every write.
- R4: Before each sprite row r, the block makes one sprite read request at address base+r. Bit 7 of the row byte is the pixel at column org_x, and bit 0 is the pixel at org_x+7.
- R5: Each sprite pixel takes a read cycle (`fb_we_o`=0) and then a write cycle at the same address. The write cycle stores the old pixel XOR the sprite bit, and a sprite bit of 0 leaves the pixel unchanged.
- R6: Pixel coordinates wrap modulo 64 in x and modulo 32 in y.
- R7: After a draw, `collide_o` is 1 exactly when some sprite bit of 1 hit a pixel that was 1. It holds until the next accepted start, which clears it. A clear leaves it 0.
- R8: `busy_o` is high from the cycle after an accepted start through the single `done_o` cycle. A draw of N rows (N>0) raises `done_o` in cycle 18·N+1 after the accepting edge. In the cycle after `done_o`, both `busy_o` and `done_o` are 0.
- R9: A start pulse while `busy_o` is high is ignored. The running operation keeps its length and result, and it makes no sprite reads.
- R10: A draw with a row count of 0 raises `done_o` in the first cycle after acceptance, with no framebuffer write and no sprite read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| draw_i | input | 1 | 1 = sprite draw, 0 = screen clear |
| org_x_i | input | 6 | Sprite origin column |
| org_y_i | input | 5 | Sprite origin line |
| rows_i | input | 4 | Number of sprite rows |
| spr_base_i | input | 12 | Address of the first sprite byte |
| spr_rd_o | output | 1 | Sprite read request |
| spr_addr_o | output | 12 | Sprite read address |
| spr_data_i | input | 8 | Sprite byte, one cycle after the request |
| fb_x_o | output | 6 | Framebuffer column address |
| fb_y_o | output | 5 | Framebuffer line address |
| fb_we_o | output | 1 | Framebuffer write strobe |
| fb_wdata_o | output | 1 | Framebuffer write bit |
| fb_rdata_i | input | 1 | Pixel read back, one cycle after the address |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| collide_o | output | 1 | A lit pixel was turned off by the last draw |

## Verification
The bench starts from a patterned screen, so a clear that skips any address leaves a visible 1 behind. It also checks that the clear visits addresses in strictly increasing order, which a design with x and y swapped in its counter would break. Sprites are drawn at the bottom-right corner so that both axes wrap; a design that saturates or carries into the wrong axis puts pixels in the wrong place in the screen image the bench keeps. One sprite is drawn twice to force a collision, and a clear afterwards must drop the flag. The bench also runs a zero-row draw and pulses start in the middle of a clear: a design that restarts or queues the second start changes the cycle count or issues sprite reads.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

  localparam int ROW_PIX = 8;
  localparam int COL_W   = $clog2(ROW_PIX);

  typedef enum logic [2:0] {
    S_IDLE,
    S_CLEAR,
    S_FETCH,
    S_LATCH,
    S_RD,
    S_WR,
    S_DONE
  } pbs_state_e;

  // Column 0 of a sprite row is the most significant bit of its byte.
  function automatic logic row_pixel(input logic [ROW_PIX-1:0] row_byte,
                                     input logic [COL_W-1:0]   col);
    return row_byte[(ROW_PIX-1) - int'(col)];
  endfunction

  function automatic logic merge_pixel(input logic old_px, input logic spr_px);
    return old_px ^ spr_px;
  endfunction

  function automatic logic pixel_hit(input logic old_px, input logic spr_px);
    return old_px & spr_px;
  endfunction

endpackage

// File: rtl/pbs_clear_scan.sv
module pbs_clear_scan #(
  parameter int X_W = 6,
  parameter int Y_W = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  output logic [X_W-1:0] x,
  output logic [Y_W-1:0] y,
  output logic           last
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x <= '0;
      y <= '0;
    end else if (load) begin
      x <= '0;
      y <= '0;
    end else if (step) begin
      if (&y) begin
        y <= '0;
        x <= x + 1'b1;
      end else begin
        y <= y + 1'b1;
      end
    end
  end

  assign last = (&x) & (&y);

  // R3: line coordinate advances fastest, column carries on line wrap
  p_line_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !(&y)) |=> (y == $past(y) + 1'b1 && x == $past(x)));

  p_col_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && (&y)) |=> (y == '0 && x == $past(x) + 1'b1));

endmodule

// File: rtl/pbs_draw_walk.sv
module pbs_draw_walk #(
  parameter int X_W    = 6,
  parameter int Y_W    = 5,
  parameter int ROW_W  = 4,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [X_W-1:0]    org_x,
  input  logic [Y_W-1:0]    org_y,
  input  logic [ROW_W-1:0]  rows,
  input  logic [ADDR_W-1:0] base,
  input  logic              col_step,
  output logic [X_W-1:0]    px,
  output logic [Y_W-1:0]    py,
  output logic [ADDR_W-1:0] spr_addr,
  output logic [pbs_pkg::COL_W-1:0] col,
  output logic              col_last,
  output logic              row_last
);

  localparam int CW = pbs_pkg::COL_W;

  logic [X_W-1:0]    ox_q;
  logic [Y_W-1:0]    oy_q;
  logic [ROW_W-1:0]  nrows_q;
  logic [ADDR_W-1:0] base_q;
  logic [ROW_W-1:0]  row_q;
  logic [CW-1:0]     col_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ox_q    <= '0;
      oy_q    <= '0;
      nrows_q <= '0;
      base_q  <= '0;
      row_q   <= '0;
      col_q   <= '0;
    end else if (load) begin
      ox_q    <= org_x;
      oy_q    <= org_y;
      nrows_q <= rows;
      base_q  <= base;
      row_q   <= '0;
      col_q   <= '0;
    end else if (col_step) begin
      if (&col_q) begin
        col_q <= '0;
        row_q <= row_q + 1'b1;
      end else begin
        col_q <= col_q + 1'b1;
      end
    end
  end

  // Power-of-two screen sizes: truncating the sum gives the wrap.
  assign px       = ox_q + X_W'(col_q);
  assign py       = oy_q + Y_W'(row_q);
  assign spr_addr = base_q + ADDR_W'(row_q);
  assign col      = col_q;
  assign col_last = &col_q;
  assign row_last = (row_q == nrows_q - 1'b1);

  // R4: after the last column of a row the next row begins at column 0
  p_row_adv_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (col_step && !load && (&col_q)) |=> (col_q == '0 && row_q == $past(row_q) + 1'b1));

  // R6: stepping one column moves the pixel one place right, modulo width
  p_col_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (col_step && !load && !(&col_q)) |=> (px == X_W'($past(px) + 1'b1)));

endmodule

// File: rtl/pbs_hit_track.sv
module pbs_hit_track (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic wr_fire,
  input  logic old_px,
  input  logic spr_px,
  output logic hit
);

  always_ff @(posedge clk) begin
    if (!rst_n)
      hit <= 1'b0;
    else if (clr)
      hit <= 1'b0;
    else if (wr_fire && pbs_pkg::pixel_hit(old_px, spr_px))
      hit <= 1'b1;
  end

  // R7: flag is sticky until the next accepted start
  p_hit_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !clr) |=> hit);

  // R7: flag only rises after a write-back that erased a lit pixel
  p_hit_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hit) |-> $past(wr_fire && old_px && spr_px));

endmodule

// File: rtl/pixel_blit_seq.sv
module pixel_blit_seq #(
  parameter int X_W    = 6,
  parameter int Y_W    = 5,
  parameter int ROW_W  = 4,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              draw_i,
  input  logic [X_W-1:0]    org_x_i,
  input  logic [Y_W-1:0]    org_y_i,
  input  logic [ROW_W-1:0]  rows_i,
  input  logic [ADDR_W-1:0] spr_base_i,
  output logic              spr_rd_o,
  output logic [ADDR_W-1:0] spr_addr_o,
  input  logic [7:0]        spr_data_i,
  output logic [X_W-1:0]    fb_x_o,
  output logic [Y_W-1:0]    fb_y_o,
  output logic              fb_we_o,
  output logic              fb_wdata_o,
  input  logic              fb_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              collide_o
);

  import pbs_pkg::*;

  pbs_state_e state_q, state_d;
  logic [ROW_PIX-1:0] row_byte_q;

  // Named internal events
  logic launch;
  logic clr_step;
  logic wr_fire;
  logic cur_bit;

  logic [X_W-1:0]    scan_x, walk_x;
  logic [Y_W-1:0]    scan_y, walk_y;
  logic              scan_last;
  logic [ADDR_W-1:0] walk_addr;
  logic [COL_W-1:0]  walk_col;
  logic              col_last, row_last;

  assign launch   = start_i && (state_q == S_IDLE);
  assign clr_step = (state_q == S_CLEAR);
  assign wr_fire  = (state_q == S_WR);
  assign cur_bit  = row_pixel(row_byte_q, walk_col);

  pbs_clear_scan #(.X_W(X_W), .Y_W(Y_W)) u_scan (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (launch),
    .step  (clr_step),
    .x     (scan_x),
    .y     (scan_y),
    .last  (scan_last)
  );

  pbs_draw_walk #(.X_W(X_W), .Y_W(Y_W), .ROW_W(ROW_W), .ADDR_W(ADDR_W)) u_walk (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (launch),
    .org_x    (org_x_i),
    .org_y    (org_y_i),
    .rows     (rows_i),
    .base     (spr_base_i),
    .col_step (wr_fire),
    .px       (walk_x),
    .py       (walk_y),
    .spr_addr (walk_addr),
    .col      (walk_col),
    .col_last (col_last),
    .row_last (row_last)
  );

  pbs_hit_track u_hit (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (launch),
    .wr_fire (wr_fire),
    .old_px  (fb_rdata_i),
    .spr_px  (cur_bit),
    .hit     (collide_o)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: begin
        if (start_i) begin
          if (!draw_i)             state_d = S_CLEAR;
          else if (rows_i == '0)   state_d = S_DONE;
          else                     state_d = S_FETCH;
        end
      end
      S_CLEAR: if (scan_last) state_d = S_DONE;
      S_FETCH: state_d = S_LATCH;
      S_LATCH: state_d = S_RD;
      S_RD:    state_d = S_WR;
      S_WR: begin
        if (!col_last)      state_d = S_RD;
        else if (row_last)  state_d = S_DONE;
        else                state_d = S_FETCH;
      end
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      row_byte_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == S_LATCH) row_byte_q <= spr_data_i;
    end
  end

  assign spr_rd_o   = (state_q == S_FETCH);
  assign spr_addr_o = walk_addr;
  assign fb_x_o     = clr_step ? scan_x : walk_x;
  assign fb_y_o     = clr_step ? scan_y : walk_y;
  assign fb_we_o    = clr_step | wr_fire;
  assign fb_wdata_o = wr_fire ? merge_pixel(fb_rdata_i, cur_bit) : 1'b0;
  assign busy_o     = (state_q != S_IDLE);
  assign done_o     = (state_q == S_DONE);

  // R1: nothing is driven in the first cycle after reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (!busy_o && !fb_we_o && !spr_rd_o && !collide_o));

  // R5: a read sub-phase is followed by a write to the same pixel
  p_read_then_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_RD) |=> (fb_we_o && fb_x_o == $past(fb_x_o) && fb_y_o == $past(fb_y_o)));

  // R4: sprite byte is requested only while no pixel is written
  p_fetch_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    spr_rd_o |-> (!fb_we_o && busy_o));

  // R8: completion is a single-cycle pulse followed by idle
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));

  // R9: a start during an operation does not end or restart it
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o && start_i) |=> busy_o);

  // R10: an empty sprite completes at once
  p_zero_rows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && draw_i && rows_i == '0) |=> (done_o && !fb_we_o));

endmodule

// File: tb/pixel_blit_seq_tb.sv
module pixel_blit_seq_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        draw_i = 1'b0;
  logic [5:0]  org_x_i = '0;
  logic [4:0]  org_y_i = '0;
  logic [3:0]  rows_i = '0;
  logic [11:0] spr_base_i = '0;
  logic        spr_rd_o;
  logic [11:0] spr_addr_o;
  logic [7:0]  spr_data_i = '0;
  logic [5:0]  fb_x_o;
  logic [4:0]  fb_y_o;
  logic        fb_we_o;
  logic        fb_wdata_o;
  logic        fb_rdata_i = 1'b0;
  logic        busy_o, done_o, collide_o;

  always #10 clk = ~clk;

  pixel_blit_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .draw_i(draw_i),
    .org_x_i(org_x_i), .org_y_i(org_y_i), .rows_i(rows_i), .spr_base_i(spr_base_i),
    .spr_rd_o(spr_rd_o), .spr_addr_o(spr_addr_o), .spr_data_i(spr_data_i),
    .fb_x_o(fb_x_o), .fb_y_o(fb_y_o), .fb_we_o(fb_we_o), .fb_wdata_o(fb_wdata_o),
    .fb_rdata_i(fb_rdata_i), .busy_o(busy_o), .done_o(done_o), .collide_o(collide_o)
  );

  int n_chk = 0;
  int n_bad = 0;

  logic fbm [0:2047];
  logic mdl [0:2047];
  logic [7:0] smem [0:255];

  // Requests latched away from the edge, served at the edge
  logic        q_we, q_wd, q_srd;
  logic [10:0] q_idx;
  logic [11:0] q_saddr;

  int wr_cnt, ord_exp, ord_bad, r5_bad, spr_n;
  logic clr_mode;
  logic p_we;
  logic [10:0] p_idx;
  logic [11:0] spr_log [0:31];

  always @(negedge clk) begin
    q_we    = fb_we_o;
    q_wd    = fb_wdata_o;
    q_idx   = {fb_x_o, fb_y_o};
    q_srd   = spr_rd_o;
    q_saddr = spr_addr_o;
    if (fb_we_o) begin
      wr_cnt++;
      if (clr_mode) begin
        if ({fb_x_o, fb_y_o} != ord_exp[10:0]) ord_bad++;
        ord_exp++;
      end else if (p_we || p_idx != {fb_x_o, fb_y_o}) begin
        r5_bad++;
      end
    end
    if (spr_rd_o && spr_n < 32) begin
      spr_log[spr_n] = spr_addr_o;
      spr_n++;
    end
    p_we  = fb_we_o;
    p_idx = {fb_x_o, fb_y_o};
  end

  always @(posedge clk) begin
    if (q_we) fbm[q_idx] <= q_wd;
    fb_rdata_i <= fbm[q_idx];
    if (q_srd) spr_data_i <= smem[q_saddr[7:0]];
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_counters(input logic is_clear);
    wr_cnt = 0; ord_exp = 0; ord_bad = 0; r5_bad = 0; spr_n = 0;
    clr_mode = is_clear; p_we = 1'b0; p_idx = '0;
  endtask

  task automatic run_op(input logic drw, input logic [5:0] x, input logic [4:0] y,
                        input logic [3:0] r, input logic [11:0] b, output int cyc);
    clear_counters(!drw);
    @(negedge clk);
    start_i = 1'b1; draw_i = drw; org_x_i = x; org_y_i = y; rows_i = r; spr_base_i = b;
    @(negedge clk);
    start_i = 1'b0;
    cyc = 1;
    while (!done_o && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  // Independent screen model for a draw; returns expected collision
  function automatic logic model_draw(input int x, input int y, input int r, input int b);
    logic hit = 1'b0;
    for (int row = 0; row < r; row++) begin
      logic [7:0] byt = smem[(b + row) % 256];
      for (int c = 0; c < 8; c++) begin
        if (byt[7 - c]) begin
          int idx = ((x + c) % 64) * 32 + ((y + row) % 32);
          if (mdl[idx]) hit = 1'b1;
          mdl[idx] = ~mdl[idx];
        end
      end
    end
    return hit;
  endfunction

  function automatic int screen_diff();
    int d = 0;
    for (int i = 0; i < 2048; i++) if (fbm[i] !== mdl[i]) d++;
    return d;
  endfunction

  function automatic int screen_ones();
    int d = 0;
    for (int i = 0; i < 2048; i++) if (fbm[i] !== 1'b0) d++;
    return d;
  endfunction

  // {org_x, org_y, rows, base, expected cycles to done}
  localparam logic [42:0] VEC [0:4] = '{
    {6'd0,  5'd0,  4'd3,  12'd0,  16'd55},
    {6'd0,  5'd0,  4'd3,  12'd0,  16'd55},
    {6'd60, 5'd30, 4'd4,  12'd8,  16'd73},
    {6'd10, 5'd5,  4'd15, 12'd16, 16'd271},
    {6'd12, 5'd7,  4'd2,  12'd20, 16'd37}
  };

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int cyc;
    logic exp_hit;
    for (int i = 0; i < 2048; i++) begin
      fbm[i] = logic'(i[0] ^ i[3]);
      mdl[i] = 1'b0;
    end
    for (int i = 0; i < 256; i++) smem[i] = 8'((i * 37 + 11) ^ (i << 3));
    q_we = 0; q_wd = 0; q_srd = 0; q_idx = '0; q_saddr = '0;
    clear_counters(1'b0);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 busy", busy_o, 0);
    chk("R1 done", done_o, 0);
    chk("R1 we", fb_we_o, 0);
    chk("R1 sprite read", spr_rd_o, 0);
    chk("R1 collide", collide_o, 0);

    // R2 / R3: clear over a patterned screen
    run_op(1'b0, 6'd0, 5'd0, 4'd0, 12'd0, cyc);
    chk("R2 clear cycles", cyc, 2049);
    chk("R2 clear writes", wr_cnt, 2048);
    chk("R3 clear order errors", ord_bad, 0);
    chk("R7 collide after clear", collide_o, 0);
    @(negedge clk);
    chk("R2 screen ones", screen_ones(), 0);
    chk("R8 idle after done", busy_o | done_o, 0);

    // Vector walk: draws
    for (int v = 0; v < 5; v++) begin
      logic [42:0] e = VEC[v];
      exp_hit = model_draw(int'(e[42:37]), int'(e[36:32]), int'(e[31:28]), int'(e[27:16]));
      run_op(1'b1, e[42:37], e[36:32], e[31:28], e[27:16], cyc);
      chk("R8 draw cycles", cyc, int'(e[15:0]));
      chk("R7 collide", collide_o, exp_hit);
      chk("R5 read-before-write pairing", r5_bad, 0);
      chk("R5 writes", wr_cnt, 8 * int'(e[31:28]));
      chk("R4 sprite fetch count", spr_n, int'(e[31:28]));
      for (int r = 0; r < int'(e[31:28]); r++)
        chk("R4 sprite fetch addr", int'(spr_log[r]), int'(e[27:16]) + r);
      @(negedge clk);
      chk("R8 idle after done", busy_o | done_o, 0);
      chk("R7 collide held", collide_o, exp_hit);
      chk("R4/R5/R6 screen image diffs", screen_diff(), 0);
    end

    // R7: force a collision, then a clear must drop the flag
    exp_hit = model_draw(0, 0, 1, 0);
    run_op(1'b1, 6'd0, 5'd0, 4'd1, 12'd0, cyc);
    chk("R7 collide repeat", collide_o, exp_hit);
    run_op(1'b0, 6'd0, 5'd0, 4'd0, 12'd0, cyc);
    for (int i = 0; i < 2048; i++) mdl[i] = 1'b0;
    chk("R7 collide cleared by clear", collide_o, 0);

    // R10: zero-row draw
    run_op(1'b1, 6'd5, 5'd5, 4'd0, 12'd0, cyc);
    chk("R10 cycles", cyc, 1);
    chk("R10 writes", wr_cnt, 0);
    chk("R10 sprite reads", spr_n, 0);
    @(negedge clk);
    chk("R10 screen ones", screen_ones(), 0);

    // R9: start during a clear is ignored
    for (int i = 0; i < 2048; i++) fbm[i] = logic'(i[1]);
    clear_counters(1'b1);
    @(negedge clk);
    start_i = 1'b1; draw_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    cyc = 1;
    while (!done_o && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      if (cyc == 100) begin
        start_i = 1'b1; draw_i = 1'b1; org_x_i = 6'd3; org_y_i = 5'd3;
        rows_i = 4'd5; spr_base_i = 12'd4;
      end else begin
        start_i = 1'b0;
      end
    end
    chk("R9 clear cycles with stray start", cyc, 2049);
    chk("R9 sprite reads", spr_n, 0);
    chk("R9 clear order errors", ord_bad, 0);
    @(negedge clk);
    chk("R9 screen ones", screen_ones(), 0);
    chk("R9 idle after done", busy_o, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule